// File: doc/BRIEF.md
# Write MESI Policy Controller

This block serves processor write requests against a small direct-mapped array that holds, for each line, a tag and a MESI coherence state. A request supplies an address, byte enables and the page write-through attribute. The block looks up the indexed line and decides whether the cached copy is updated. It also decides whether the write goes out on the bus as a write-through cycle of one to eight bytes. When the write finishes, the block records the line's new state. It does not hold line data. It only strobes the data array with the address and byte enables it should merge.

A write to an invalid line, or to a line with a different tag, counts as a miss. A miss is sent to memory and allocates nothing. A write that hits an exclusive or modified line stays on chip and leaves the line modified. A write that hits a shared line updates the cache and is also sent to memory. Its final state is decided when the bus write completes: the page attribute and the write-back/write-through sample taken in the bus-ready cycle choose between shared and exclusive.

A narrow install port lets the neighbouring read-fill logic place a tag and state into a line. That port is blocked in debug mode, because reads never fill the cache there. Write handling works the same way whether or not debug mode is on.

Top module: `wmesi_write_ctrl`

## Requirements
- R1: After reset every line is invalid (state code 00), `req_ready` is high, and `bus_req`, `cache_we`, `done` and `upd_valid` are low.
- R2: A write whose line is invalid or whose stored tag differs from the address tag is a miss. It raises no `cache_we` and leaves the line unchanged. It raises `bus_req` with the request's address and byte enables two edges after acceptance. It ends with `done` high and `upd_valid` low on the edge that samples `bus_rdy`.
- R3: A write hit on an exclusive (10) or modified (11) line raises `cache_we` with the request's address and byte enables two edges after acceptance. On that same edge it raises `done` and `upd_valid` with `upd_state` = 11 and sets the line to modified. No bus write is issued.
- R4: A write hit on a shared (01) line raises `cache_we` and `bus_req` together, two edges after acceptance.
- R5: A shared-line hit with the page write-through bit at 1 leaves the line shared, whatever the value of `bus_wbwt`.
- R6: A shared-line hit with the page write-through bit at 0 and `bus_wbwt` at 0 leaves the line shared.
- R7: A shared-line hit with the page write-through bit at 0 and `bus_wbwt` at 1 makes the line exclusive (10). A later write to that line is an on-chip hit.
- R8: `bus_req`, `bus_addr` and `bus_be` hold until `bus_rdy`. `bus_wbwt` is used only in the cycle where `bus_rdy` is high. The new state, `upd_valid` and `done` are registered on that same edge and not before.
- R9: `fill_valid` writes `fill_tag` and `fill_state` into line `fill_idx` only while the block is idle and `dbg_mode` is low. In debug mode it is ignored, and write requests are handled exactly as outside debug mode.
- R10: A request is accepted only while `req_ready` is high. `req_valid` or `fill_valid` presented while the block is busy is dropped, and each accepted write produces exactly one single-cycle `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Byte address of the write |
| req_be | input | BE_W | Byte enables of the write |
| req_pwt | input | 1 | Page write-through attribute |
| req_ready | output | 1 | Block idle, request can be taken |
| dbg_mode | input | 1 | Debug mode, blocks line installs |
| fill_valid | input | 1 | Install a line from the fill side |
| fill_idx | input | IDX_W | Line index to install |
| fill_tag | input | TAG_W | Tag to install |
| fill_state | input | 2 | State to install (00 I, 01 S, 10 E, 11 M) |
| bus_req | output | 1 | Write-through bus cycle requested |
| bus_addr | output | ADDR_W | Address of the bus write |
| bus_be | output | BE_W | Byte enables of the bus write |
| bus_rdy | input | 1 | Bus write completes this cycle |
| bus_wbwt | input | 1 | Write-back (1) / write-through (0) sample |
| cache_we | output | 1 | Data array update strobe |
| cache_addr | output | ADDR_W | Address for the data array update |
| cache_be | output | BE_W | Byte enables for the data array update |
| done | output | 1 | Write finished (one cycle) |
| upd_valid | output | 1 | Line state changed on a hit |
| upd_state | output | 2 | New state of the line |

## Verification
The hardest case to reach is a shared-line hit that turns exclusive. It needs a shared line already installed, the page bit low, and `bus_wbwt` high in exactly the ready cycle. The stimulus installs shared lines through the fill port, holds `bus_rdy` back for several cycles while driving `bus_wbwt` to the opposite value, and flips it only in the ready cycle. A follow-up write to the same line then shows the recorded state at the ports, as either an on-chip hit or a second bus write. Writes poked in while the bus is busy, and fills made in debug mode, are exposed the same way by later writes.

// File: rtl/wmesi_pkg.sv
package wmesi_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOOK = 2'b01,
    PH_BUS  = 2'b10
  } phase_t;
endpackage

// File: rtl/wmesi_line_array.sv
module wmesi_line_array
  import wmesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output mesi_t            rd_state,
  input  logic             wr_en,
  input  logic             wr_tag_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  mesi_t            wr_state
);
  logic [TAG_W-1:0] tag_mem [LINES];
  mesi_t            st_q    [LINES];

  // Tag store: no reset, registered read, so it can sit in block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // State bits are reset to invalid on every line.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= MESI_I;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_state <= MESI_I;
    else if (rd_en) rd_state <= st_q[rd_idx];
  end
endmodule

// File: rtl/wmesi_policy.sv
module wmesi_policy
  import wmesi_pkg::*;
(
  input  mesi_t line_state,
  input  logic  tag_match,
  input  logic  pwt,
  input  logic  wbwt,
  output logic  hit,
  output logic  owned,
  output mesi_t shared_next
);
  always_comb begin
    hit         = tag_match && (line_state != MESI_I);
    owned       = hit && ((line_state == MESI_E) || (line_state == MESI_M));
    shared_next = (pwt || !wbwt) ? MESI_S : MESI_E;
  end
endmodule

// File: rtl/wmesi_ctrl.sv
module wmesi_ctrl
  import wmesi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 5,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_pwt,
  output logic              idle,
  output logic              la_rd_en,
  output logic [IDX_W-1:0]  la_rd_idx,
  input  logic [TAG_W-1:0]  la_tag,
  input  mesi_t             la_state,
  output logic              la_wr_en,
  output logic [IDX_W-1:0]  la_wr_idx,
  output mesi_t             la_wr_state,
  input  logic              bus_rdy,
  input  logic              bus_wbwt,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              cache_we,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [BE_W-1:0]   cache_be,
  output logic              done,
  output logic              upd_valid,
  output mesi_t             upd_state
);
  phase_t            ph;
  logic [ADDR_W-1:0] l_addr;
  logic [BE_W-1:0]   l_be;
  logic              l_pwt;
  logic              l_shared;
  logic              hit, owned;
  mesi_t             shared_next;

  wmesi_policy u_policy (
    .line_state (la_state),
    .tag_match  (la_tag == l_addr[ADDR_W-1 -: TAG_W]),
    .pwt        (l_pwt),
    .wbwt       (bus_wbwt),
    .hit        (hit),
    .owned      (owned),
    .shared_next(shared_next)
  );

  assign idle      = (ph == PH_IDLE);
  assign la_rd_en  = idle && req_valid;
  assign la_rd_idx = req_addr[OFF_W +: IDX_W];
  assign la_wr_idx = l_addr[OFF_W +: IDX_W];

  always_comb begin
    la_wr_en    = 1'b0;
    la_wr_state = MESI_M;
    if (ph == PH_LOOK && owned) begin
      la_wr_en = 1'b1;
    end else if (ph == PH_BUS && bus_rdy && l_shared) begin
      la_wr_en    = 1'b1;
      la_wr_state = shared_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      l_addr     <= '0;
      l_be       <= '0;
      l_pwt      <= 1'b0;
      l_shared   <= 1'b0;
      bus_req    <= 1'b0;
      bus_addr   <= '0;
      bus_be     <= '0;
      cache_we   <= 1'b0;
      cache_addr <= '0;
      cache_be   <= '0;
      done       <= 1'b0;
      upd_valid  <= 1'b0;
      upd_state  <= MESI_I;
    end else begin
      cache_we  <= 1'b0;
      done      <= 1'b0;
      upd_valid <= 1'b0;
      case (ph)
        PH_IDLE: if (req_valid) begin
          l_addr <= req_addr;
          l_be   <= req_be;
          l_pwt  <= req_pwt;
          ph     <= PH_LOOK;
        end
        PH_LOOK: begin
          cache_we   <= hit;
          cache_addr <= l_addr;
          cache_be   <= l_be;
          if (owned) begin
            done      <= 1'b1;
            upd_valid <= 1'b1;
            upd_state <= MESI_M;
            ph        <= PH_IDLE;
          end else begin
            l_shared <= hit;
            bus_req  <= 1'b1;
            bus_addr <= l_addr;
            bus_be   <= l_be;
            ph       <= PH_BUS;
          end
        end
        PH_BUS: if (bus_rdy) begin
          bus_req <= 1'b0;
          done    <= 1'b1;
          ph      <= PH_IDLE;
          if (l_shared) begin
            upd_valid <= 1'b1;
            upd_state <= shared_next;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  a_r2_miss_ends_on_bus: assert property (@(posedge clk) disable iff (rst)
    (done && !upd_valid) |-> $past(bus_req && bus_rdy));
  a_r8_commit_on_bus: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_state != MESI_M) |-> $past(bus_req && bus_rdy));
  a_r3_owned_no_bus: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_state == MESI_M) |-> !$past(bus_req));
  a_r8_hold_bus: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/wmesi_write_ctrl.sv
module wmesi_write_ctrl
  import wmesi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BE_W       = 8,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_pwt,
  output logic              req_ready,
  input  logic              dbg_mode,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [1:0]        fill_state,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  input  logic              bus_rdy,
  input  logic              bus_wbwt,
  output logic              cache_we,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [BE_W-1:0]   cache_be,
  output logic              done,
  output logic              upd_valid,
  output logic [1:0]        upd_state
);
  logic             idle, rd_en, up_we, fill_take, wr_en;
  logic [IDX_W-1:0] rd_idx, up_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag;
  mesi_t            rd_state, up_state, wr_state, upd_state_t;

  assign fill_take = fill_valid && !dbg_mode && idle;
  assign wr_en     = up_we || fill_take;
  assign wr_idx    = up_we ? up_idx : fill_idx;
  assign wr_state  = up_we ? up_state : mesi_t'(fill_state);
  assign req_ready = idle;
  assign upd_state = upd_state_t;

  wmesi_line_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_tag   (rd_tag),
    .rd_state (rd_state),
    .wr_en    (wr_en),
    .wr_tag_en(!up_we),
    .wr_idx   (wr_idx),
    .wr_tag   (fill_tag),
    .wr_state (wr_state)
  );

  wmesi_ctrl #(.ADDR_W(ADDR_W), .BE_W(BE_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_pwt    (req_pwt),
    .idle       (idle),
    .la_rd_en   (rd_en),
    .la_rd_idx  (rd_idx),
    .la_tag     (rd_tag),
    .la_state   (rd_state),
    .la_wr_en   (up_we),
    .la_wr_idx  (up_idx),
    .la_wr_state(up_state),
    .bus_rdy    (bus_rdy),
    .bus_wbwt   (bus_wbwt),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .cache_we   (cache_we),
    .cache_addr (cache_addr),
    .cache_be   (cache_be),
    .done       (done),
    .upd_valid  (upd_valid),
    .upd_state  (upd_state_t)
  );

  a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rdy) |=> !req_ready);
endmodule

// File: tb/tb_wmesi_write_ctrl.sv
`timescale 1ns/1ps
module tb_wmesi_write_ctrl;
  localparam int ADDR_W = 32, BE_W = 8, LINES = 16, LINE_BYTES = 32;
  localparam int IDX_W = 4, OFF_W = 5, TAG_W = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_pwt = 0, dbg_mode = 0, fill_valid = 0, bus_rdy = 0, bus_wbwt = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0]   req_be = '0;
  logic [IDX_W-1:0]  fill_idx = '0;
  logic [TAG_W-1:0]  fill_tag = '0;
  logic [1:0]        fill_state = '0;
  logic req_ready, bus_req, cache_we, done, upd_valid;
  logic [ADDR_W-1:0] bus_addr, cache_addr;
  logic [BE_W-1:0]   bus_be, cache_be;
  logic [1:0]        upd_state;

  always #10 clk = ~clk;

  wmesi_write_ctrl #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .req_pwt(req_pwt), .req_ready(req_ready), .dbg_mode(dbg_mode), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_state(fill_state), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdy(bus_rdy), .bus_wbwt(bus_wbwt),
    .cache_we(cache_we), .cache_addr(cache_addr), .cache_be(cache_be), .done(done),
    .upd_valid(upd_valid), .upd_state(upd_state)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference: phase 0 idle, 1 lookup, 2 waiting on bus.
  int m_st [LINES];
  logic [TAG_W-1:0] m_tag [LINES];
  int ph = 0;
  logic [ADDR_W-1:0] l_addr;
  logic [BE_W-1:0] l_be;
  bit l_pwt, l_shared;
  bit e_bus_req, e_cache_we, e_done, e_upd_valid;
  logic [ADDR_W-1:0] e_bus_addr, e_cache_addr;
  logic [BE_W-1:0] e_bus_be, e_cache_be;
  int e_upd_state;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0;
      for (int i = 0; i < LINES; i++) m_st[i] = 0;
      e_bus_req = 0; e_cache_we = 0; e_done = 0; e_upd_valid = 0;
    end else begin
      e_cache_we = 0; e_done = 0; e_upd_valid = 0;
      if (ph == 0) begin
        if (fill_valid && !dbg_mode) begin
          m_st[fill_idx] = fill_state;
          m_tag[fill_idx] = fill_tag;
        end
        if (req_valid) begin
          l_addr = req_addr; l_be = req_be; l_pwt = req_pwt; ph = 1;
        end
      end else if (ph == 1) begin
        int ix;
        bit hit;
        ix = l_addr[8:5];
        hit = (m_st[ix] != 0) && (m_tag[ix] == l_addr[31:9]);
        if (hit) begin
          e_cache_we = 1; e_cache_addr = l_addr; e_cache_be = l_be;
        end
        if (hit && m_st[ix] >= 2) begin
          m_st[ix] = 3; e_done = 1; e_upd_valid = 1; e_upd_state = 3; ph = 0;
        end else begin
          l_shared = hit; e_bus_req = 1; e_bus_addr = l_addr; e_bus_be = l_be; ph = 2;
        end
      end else if (bus_rdy) begin
        e_bus_req = 0; e_done = 1; ph = 0;
        if (l_shared) begin
          int ns;
          ns = (l_pwt || !bus_wbwt) ? 1 : 2;
          m_st[l_addr[8:5]] = ns;
          e_upd_valid = 1; e_upd_state = ns;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_ready == (ph == 0), "req_ready", req_ready, ph == 0);
      chk(bus_req == e_bus_req, "bus_req", bus_req, e_bus_req);
      if (e_bus_req) begin
        chk(bus_addr == e_bus_addr, "bus_addr", bus_addr, e_bus_addr);
        chk(bus_be == e_bus_be, "bus_be", bus_be, e_bus_be);
      end
      chk(cache_we == e_cache_we, "cache_we", cache_we, e_cache_we);
      if (e_cache_we) begin
        chk(cache_addr == e_cache_addr, "cache_addr", cache_addr, e_cache_addr);
        chk(cache_be == e_cache_be, "cache_be", cache_be, e_cache_be);
      end
      chk(done == e_done, "done", done, e_done);
      chk(upd_valid == e_upd_valid, "upd_valid", upd_valid, e_upd_valid);
      if (e_upd_valid) chk(upd_state == e_upd_state[1:0], "upd_state", upd_state, e_upd_state);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int tag, input int ix, input int off);
    return {tag[22:0], ix[3:0], off[4:0]};
  endfunction

  task automatic do_fill(input int ix, input int tag, input int st);
    fill_valid = 1; fill_idx = ix[3:0]; fill_tag = tag[22:0]; fill_state = st[1:0];
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] be, input bit pwt,
                          input int dly, input bit w, input bit poke);
    int waited;
    bit fin;
    waited = 0; fin = 0;
    req_valid = 1; req_addr = a; req_be = be; req_pwt = pwt; bus_wbwt = ~w;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 40 && !fin; k++) begin
      @(negedge clk);
      req_valid = 0; fill_valid = 0;
      if (done) fin = 1;
      else if (bus_req) begin
        if (waited == dly) begin
          bus_rdy = 1; bus_wbwt = w;
          @(negedge clk);
          bus_rdy = 0; bus_wbwt = ~w;
          fin = 1;
        end else begin
          if (poke && waited == 0) begin
            req_valid = 1; req_addr = mk(77, 10, 0); req_be = 8'hff; req_pwt = 0;
            fill_valid = 1; fill_idx = 4'd10; fill_tag = 23'd77; fill_state = 2'b10;
          end
          waited++;
        end
      end
    end
    req_valid = 0; fill_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk(req_ready === 1'b1, "reset req_ready", req_ready, 1);
    chk(bus_req === 1'b0, "reset bus_req", bus_req, 0);
    chk(cache_we === 1'b0, "reset cache_we", cache_we, 0);
    chk(done === 1'b0 && upd_valid === 1'b0, "reset done/upd", {done, upd_valid}, 0);
    do_write(mk(5, 3, 8), 8'h0f, 0, 0, 1, 0);       // all lines start invalid
    do_write(mk(1, 0, 0), 8'hff, 1, 1, 1, 0);

    cur_req = "R2";
    do_fill(3, 7, 2);
    do_write(mk(5, 3, 16), 8'h30, 0, 2, 1, 0);      // tag mismatch
    do_fill(4, 9, 0);
    do_write(mk(9, 4, 0), 8'h01, 0, 0, 0, 0);       // invalid line, matching tag

    cur_req = "R3";
    do_write(mk(7, 3, 4), 8'hf0, 0, 0, 1, 0);       // E -> M
    do_write(mk(7, 3, 24), 8'h80, 1, 0, 0, 0);      // M stays M
    do_fill(5, 2, 3);
    do_write(mk(2, 5, 0), 8'h3c, 0, 0, 0, 0);

    cur_req = "R4";
    do_fill(6, 1, 1);
    cur_req = "R5";
    do_write(mk(1, 6, 0), 8'h0f, 1, 2, 1, 0);       // pwt=1 keeps S
    cur_req = "R6";
    do_write(mk(1, 6, 8), 8'hff, 0, 1, 0, 0);       // wbwt=0 keeps S
    cur_req = "R7";
    do_write(mk(1, 6, 16), 8'h11, 0, 0, 1, 0);      // S -> E
    do_write(mk(1, 6, 16), 8'h22, 0, 0, 0, 0);      // now on-chip hit

    cur_req = "R8";
    do_fill(7, 11, 1);
    do_write(mk(11, 7, 0), 8'h06, 0, 6, 1, 0);      // long wait, wbwt toggled
    do_write(mk(11, 7, 0), 8'h60, 0, 0, 0, 0);

    cur_req = "R9";
    do_fill(9, 4, 1);
    dbg_mode = 1;
    do_fill(8, 3, 2);                               // dropped in debug mode
    do_write(mk(3, 8, 0), 8'hff, 0, 0, 1, 0);
    do_write(mk(4, 9, 0), 8'h03, 0, 1, 1, 0);       // S -> E in debug mode
    do_write(mk(4, 9, 0), 8'h0c, 0, 0, 1, 0);
    dbg_mode = 0;

    cur_req = "R10";
    do_write(mk(50, 12, 0), 8'h55, 0, 3, 0, 1);     // req and fill poked while busy
    do_write(mk(77, 10, 0), 8'haa, 0, 0, 1, 0);     // poked fill must not exist

    cur_req = "R4";
    for (int i = 0; i < LINES; i++) do_fill(i, 100 + i, i % 4);
    for (int i = 0; i < LINES; i++)
      do_write(mk(100 + i, i, i), 8'h1 << (i % 8), i[0], i % 3, i[1], 0);
    for (int i = 0; i < LINES; i++)
      do_write(mk(100 + i, i, 0), 8'hc3, 0, 1, 1, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule